// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host access to a bank of 16-bit indirect registers through a small set of direct registers on a simple synchronous register bus. Two of these direct registers do the work. The first is a data staging register. The second is an address register.

A host write to the address register starts a transfer. The direction of that transfer depends on what came before it:

- If the staging register was written since the last address write, the request is a store. The staged value is written to the addressed location.
- If it was not, the request is a fetch. The addressed location's value is copied into the staging register.

At most one request waits at a time. A waiting request is carried out only on a single-cycle update tick, which an external prescaler supplies at a low, fixed rate.

A pending bit shows that a request is waiting. A sticky completion flag is set when a request is carried out. The host clears the flag by writing one to it. The flag drives an interrupt output when its enable bit is set.

The indirect storage is written so that it maps onto block RAM. It is written only by serviced store requests. It is read through a registered port that follows the requested address. The storage has no reset, so its contents are undefined until written.

Top module: `indreg_bridge`

## Requirements
- R1: A write to the staging register (direct address 28), followed by a write to the address register (direct address 29, location in the low bits of the write data), makes a store request. At the next servicing tick, the staged value is written to that location.
- R2: An address-register write with no staging-register write since the previous address-register write makes a fetch request. At the next servicing tick, the staging register is loaded with the value at the addressed location. The host reads the staging register back at direct address 28.
- R3: Each address-register write consumes the staging-written flag. A second address-register write with no new staging write is therefore a fetch, even right after a store.
- R4: The pending bit (bit 0 of direct address 31) reads one from the cycle after an address-register write until the cycle after the tick that services the request.
- R5: Without a tick, a pending request stays pending. Neither the storage nor the staging register changes.
- R6: An address-register write while a request is pending replaces that request. The replaced request is never carried out. The new direction follows the staging-written flag at that moment.
- R7: A tick in the same cycle as an address-register write services nothing. The new request stays pending for the next tick.
- R8: The completion flag (bit 0 of direct address 20) is set when a request is serviced. It holds until the host writes one to that bit. Writing zero to that bit has no effect.
- R9: The interrupt output equals the completion flag ANDed with the enable bit (bit 0 of direct address 21), registered one cycle later.
- R10: After synchronous reset, the pending bit, completion flag, enable bit, interrupt output and staging register are all zero.
- R11: A tick with no request pending changes nothing and does not set the completion flag.
- R12: Host read data is registered and valid in the cycle after the read strobe. Unmapped direct addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_tick | input | 1 | Single-cycle update event from the prescaler |
| host_addr | input | 5 | Direct register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Completion interrupt |

## Verification
Two functions can fall in the same cycle: a host address-register write and the update tick. When they coincide, the request must stay pending and must not be serviced. The bench provokes this by driving the tick and the address write in one cycle. It then checks that the pending bit is still one and that the completion flag stays clear. A later lone tick must then deliver the value stored at the newly requested location. The replacement case is judged the same way: after a second address write overrides a pending store, the overridden location is fetched back and must still hold its earlier value.

// File: rtl/indreg_pkg.sv
package indreg_pkg;
  localparam int HA_W = 5;
  localparam logic [HA_W-1:0] OFS_IRQ   = 5'd20;
  localparam logic [HA_W-1:0] OFS_IRQEN = 5'd21;
  localparam logic [HA_W-1:0] OFS_DATA  = 5'd28;
  localparam logic [HA_W-1:0] OFS_ADDR  = 5'd29;
  localparam logic [HA_W-1:0] OFS_STAT  = 5'd31;

  typedef enum logic {DIR_FETCH = 1'b0, DIR_STORE = 1'b1} dir_e;
endpackage

// File: rtl/indreg_store.sv
module indreg_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/indreg_ctrl.sv
module indreg_ctrl
  import indreg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          data_wr,
  input  logic          addr_wr,
  input  logic [AW-1:0] new_addr,
  output logic          pend,
  output dir_e          req_dir,
  output logic [AW-1:0] req_addr,
  output logic          svc
);
  logic staged;

  // a tick coinciding with a new request is not used
  assign svc = pend & tick & ~addr_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged   <= 1'b0;
      pend     <= 1'b0;
      req_dir  <= DIR_FETCH;
      req_addr <= '0;
    end else if (addr_wr) begin
      pend     <= 1'b1;
      req_dir  <= staged ? DIR_STORE : DIR_FETCH;
      req_addr <= new_addr;
      staged   <= 1'b0;
    end else begin
      if (data_wr) staged <= 1'b1;
      if (svc)     pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/indreg_bridge.sv
module indreg_bridge
  import indreg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_tick,
  input  logic [HA_W-1:0] host_addr,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            irq_out
);
  logic          data_wr, addr_wr, clr_wr, en_wr;
  logic          pend, svc;
  dir_e          req_dir;
  logic [AW-1:0] req_addr, rd_addr;
  logic [DW-1:0] data_q, rd_q;
  logic          irq_flag, irq_en;

  assign data_wr = host_wr && (host_addr == OFS_DATA);
  assign addr_wr = host_wr && (host_addr == OFS_ADDR);
  assign clr_wr  = host_wr && (host_addr == OFS_IRQ) && host_wdata[0];
  assign en_wr   = host_wr && (host_addr == OFS_IRQEN);

  indreg_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .tick(upd_tick),
    .data_wr(data_wr), .addr_wr(addr_wr), .new_addr(host_wdata[AW-1:0]),
    .pend(pend), .req_dir(req_dir), .req_addr(req_addr), .svc(svc)
  );

  // read port follows the incoming address so rd_q is ready one cycle later
  assign rd_addr = addr_wr ? host_wdata[AW-1:0] : req_addr;

  indreg_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(svc && req_dir == DIR_STORE), .waddr(req_addr),
    .wdata(data_q), .raddr(rd_addr), .rdata(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      irq_flag <= 1'b0;
      irq_en   <= 1'b0;
      irq_out  <= 1'b0;
    end else begin
      if (data_wr)                              data_q <= host_wdata;
      else if (svc && req_dir == DIR_FETCH)     data_q <= rd_q;
      if (svc)         irq_flag <= 1'b1;
      else if (clr_wr) irq_flag <= 1'b0;
      if (en_wr) irq_en <= host_wdata[0];
      irq_out <= irq_flag & irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) begin
      unique case (host_addr)
        OFS_DATA:  host_rdata <= data_q;
        OFS_ADDR:  host_rdata <= {{(DW-AW){1'b0}}, req_addr};
        OFS_STAT:  host_rdata <= {{(DW-1){1'b0}}, pend};
        OFS_IRQ:   host_rdata <= {{(DW-1){1'b0}}, irq_flag};
        OFS_IRQEN: host_rdata <= {{(DW-1){1'b0}}, irq_en};
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/indreg_chk.sv
module indreg_chk (
  input logic clk,
  input logic rst,
  input logic upd_tick,
  input logic addr_wr,
  input logic pend,
  input logic irq_flag,
  input logic irq_en,
  input logic irq_out
);
  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> pend);
  // R7
  tick_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_wr && upd_tick) |=> (pend && $stable(irq_flag)));
  // R5
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !upd_tick) |=> pend);
  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && upd_tick && !addr_wr) |=> (irq_flag && !pend));
  // R11
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && !addr_wr && !irq_flag) |=> !irq_flag);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_out);
endmodule

bind indreg_bridge indreg_chk u_chk (
  .clk(clk), .rst(rst), .upd_tick(upd_tick), .addr_wr(addr_wr),
  .pend(pend), .irq_flag(irq_flag), .irq_en(irq_en), .irq_out(irq_out)
);

// File: tb/sim_indreg_bridge.sv
module sim_indreg_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_tick = 1'b0;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq_out;
  int tests = 0;
  int fails = 0;

  localparam logic [4:0] A_IRQ = 5'd20, A_EN = 5'd21, A_DATA = 5'd28,
                         A_ADDR = 5'd29, A_STAT = 5'd31;

  always #2 clk = ~clk;

  indreg_bridge u0 (.*);

  function automatic logic [15:0] val(input int a);
    return 16'((a * 16'h0F1D) + 16'h8001);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [15:0] d, input logic tk = 1'b0);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1; upd_tick = tk;
    @(negedge clk);
    host_wr = 1'b0; upd_tick = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    upd_tick = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    hread(A_STAT, r); check("R10 pend", r, 16'h0);
    hread(A_IRQ, r);  check("R10 flag", r, 16'h0);
    hread(A_EN, r);   check("R10 enable", r, 16'h0);
    hread(A_DATA, r); check("R10 data", r, 16'h0);
    check("R10 irq_out", {15'h0, irq_out}, 16'h0);
    // R11 idle tick
    tick();
    hread(A_IRQ, r); check("R11 idle tick flag", r, 16'h0);
    // R12 unmapped reads zero
    hread(5'd10, r); check("R12 unmapped", r, 16'h0);
    // R1 store sweep with R4, R5, R8
    for (int a = 0; a < 16; a++) begin
      hwrite(A_DATA, val(a));
      hwrite(A_ADDR, 16'(a));
      hread(A_STAT, r); check("R4 pend set", r, 16'h1);
      idle(3);
      hread(A_STAT, r); check("R5 pend held", r, 16'h1);
      hread(A_IRQ, r);  check("R5 no flag without tick", r, 16'h0);
      tick();
      hread(A_STAT, r); check("R4 pend cleared", r, 16'h0);
      hread(A_IRQ, r);  check("R8 flag set", r, 16'h1);
      hwrite(A_IRQ, 16'h0);
      hread(A_IRQ, r);  check("R8 zero write ignored", r, 16'h1);
      hwrite(A_IRQ, 16'h1);
      hread(A_IRQ, r);  check("R8 flag cleared", r, 16'h0);
    end
    // R2 fetch sweep, in reverse order
    for (int a = 15; a >= 0; a--) begin
      hwrite(A_ADDR, 16'(a));
      tick();
      hread(A_DATA, r); check("R2 fetch", r, val(a));
    end
    hwrite(A_IRQ, 16'h1);
    // R3 second address write is a fetch
    hwrite(A_DATA, 16'h7E57);
    hwrite(A_ADDR, 16'd2);
    tick();
    hwrite(A_ADDR, 16'd9);
    tick();
    hread(A_DATA, r); check("R3 consumed flag fetch", r, val(9));
    hwrite(A_ADDR, 16'd2);
    tick();
    hread(A_DATA, r); check("R1 stored value", r, 16'h7E57);
    // R6 replacement of a pending store by a fetch
    hwrite(A_DATA, 16'h1234);
    hwrite(A_ADDR, 16'd3);
    hwrite(A_ADDR, 16'd5);
    tick();
    hread(A_DATA, r); check("R6 replacement fetch", r, val(5));
    hwrite(A_ADDR, 16'd3);
    tick();
    hread(A_DATA, r); check("R6 replaced store dropped", r, val(3));
    hwrite(A_IRQ, 16'h1);
    // R7 tick in same cycle as address write
    hwrite(A_ADDR, 16'd7, 1'b1);
    hread(A_STAT, r); check("R7 still pending", r, 16'h1);
    hread(A_IRQ, r);  check("R7 no completion", r, 16'h0);
    tick();
    hread(A_DATA, r); check("R7 later fetch", r, val(7));
    // R9 interrupt gating
    hread(A_IRQ, r); check("R8 flag before gating", r, 16'h1);
    idle(2);
    check("R9 masked", {15'h0, irq_out}, 16'h0);
    hwrite(A_EN, 16'h1);
    idle(2);
    check("R9 enabled", {15'h0, irq_out}, 16'h1);
    hwrite(A_IRQ, 16'h1);
    idle(2);
    check("R9 cleared", {15'h0, irq_out}, 16'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule